// File: doc/BRIEF.md
# Phased Minority-Gate 2-to-4 Decoder

This block is a cycle-level model of a 2-to-4 decoder with an active-low enable. Each output comes from a five-input minority gate. Two inputs of every gate are tied to logic 1, which turns the gate into a NOR of its remaining three operands. Those operands are the enable and the two address bits. Each one is held in a storage cell whose fixed polarity yields either the true or the complemented form of the input. No inverter is needed anywhere.

A six-step sequencer runs every cycle of the block:

- **ST_CLEAR** (unit 0) forces every storage cell to its polarity value.
- **ST_LOAD0** and **ST_LOAD1** (units 1–2) capture the inputs.
- **ST_EVAL0**, **ST_EVAL1** and **ST_EVAL2** (units 3–5) freeze the cells and let the gates drive the output register.

The transitions are ST_CLEAR→ST_LOAD0→ST_LOAD1→ST_EVAL0→ST_EVAL1→ST_EVAL2, and ST_EVAL2 returns to ST_CLEAR. A surrounding system drives the enable and the address before the load units. It then reads the four outputs while the valid pulse is high.

Top module: `phased_minority_decoder`

## Requirements
- R1: Each output is a five-input minority function, which is 1 when fewer than three of its inputs are 1. Two of the five inputs are constant 1, so an output is 1 exactly when all three of its stored operands are 0.
- R2: The gates use operands (en_n, A1, A0) for dec_out[0], (en_n, A1, ~A0) for dec_out[1], (en_n, ~A1, A0) for dec_out[2] and (en_n, ~A1, ~A0) for dec_out[3]. Here A1 is addr[1] and A0 is addr[0]. With en_n=1 all outputs are 0. With en_n=0 only dec_out[addr] is 1.
- R3: The step sequence repeats with a period of 6 clocks. phase_code reads 0 in unit 0, 1 in units 1–2 and 2 in units 3–5.
- R4: In unit 0 every storage cell is forced to its polarity value: 0 for a true-form operand, 1 for a complemented one. Inputs loaded in one cycle therefore never leak into the next cycle.
- R5: At a load unit, an input of 1 sets its cell to the inverse of its polarity. An input of 0 leaves the cell as it is. A 1 at unit 1 followed by a 0 at unit 2 therefore still counts as 1.
- R6: Input values present outside units 1–2 have no effect on the result of that cycle.
- R7: dec_out changes only on the clock edges that end units 3, 4 and 5. It holds its previous value through units 0–2.
- R8: result_valid is 1 during unit 5 only, for one clock per cycle.
- R9: A synchronous reset returns the sequencer to unit 0 and clears dec_out and result_valid to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en_n | input | 1 | Active-low enable operand |
| addr | input | 2 | Address operands; bit 1 is A1, bit 0 is A0 |
| dec_out | output | 4 | Registered decoder outputs |
| phase_code | output | 2 | 0 = clear, 1 = load, 2 = evaluate |
| result_valid | output | 1 | One-clock pulse in the last evaluate unit |

## Verification
Faults in the internal state show up at the ports within one cycle of six clocks. A storage cell with a wrong polarity, or a missed clear, gives the wrong one-hot code at the next valid pulse. A cell that keeps loading after unit 2 lets late input changes alter that pulse. A sequencer that skips or repeats a step moves phase_code and the valid pulse away from their fixed units. An output register that updates outside the evaluate units shows a new value during units 0–2, before the next valid pulse.

// File: rtl/mdec_pkg.sv
package mdec_pkg;

    typedef enum logic [2:0] {
        ST_CLEAR = 3'd0,
        ST_LOAD0 = 3'd1,
        ST_LOAD1 = 3'd2,
        ST_EVAL0 = 3'd3,
        ST_EVAL1 = 3'd4,
        ST_EVAL2 = 3'd5
    } step_t;

    localparam logic [1:0] PH_CLEAR = 2'd0;
    localparam logic [1:0] PH_LOAD  = 2'd1;
    localparam logic [1:0] PH_EVAL  = 2'd2;

endpackage

// File: rtl/mdec_sequencer.sv
module mdec_sequencer
    import mdec_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    output logic       clear_en,
    output logic       load_en,
    output logic       eval_en,
    output logic       last_eval,
    output logic [1:0] phase_code
);

    step_t step_q;
    step_t step_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            step_q <= ST_CLEAR;
        end else begin
            step_q <= step_d;
        end
    end

    // transitions
    always_comb begin
        unique case (step_q)
            ST_CLEAR: step_d = ST_LOAD0;
            ST_LOAD0: step_d = ST_LOAD1;
            ST_LOAD1: step_d = ST_EVAL0;
            ST_EVAL0: step_d = ST_EVAL1;
            ST_EVAL1: step_d = ST_EVAL2;
            ST_EVAL2: step_d = ST_CLEAR;
            default:  step_d = ST_CLEAR;
        endcase
    end

    // outputs
    always_comb begin
        clear_en   = 1'b0;
        load_en    = 1'b0;
        eval_en    = 1'b0;
        last_eval  = 1'b0;
        phase_code = PH_CLEAR;
        unique case (step_q)
            ST_CLEAR: begin
                clear_en   = 1'b1;
                phase_code = PH_CLEAR;
            end
            ST_LOAD0, ST_LOAD1: begin
                load_en    = 1'b1;
                phase_code = PH_LOAD;
            end
            ST_EVAL0, ST_EVAL1: begin
                eval_en    = 1'b1;
                phase_code = PH_EVAL;
            end
            ST_EVAL2: begin
                eval_en    = 1'b1;
                last_eval  = 1'b1;
                phase_code = PH_EVAL;
            end
            default: begin
                phase_code = PH_CLEAR;
            end
        endcase
    end

    // R3
    step_advance_chk: assert property (@(posedge clk) disable iff (rst)
        (step_q != ST_EVAL2) |=> (step_q == step_t'($past(step_q) + 3'd1)));

    // R3
    step_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (step_q == ST_EVAL2) |=> (step_q == ST_CLEAR));

endmodule

// File: rtl/mdec_store_cell.sv
module mdec_store_cell #(
    parameter bit POLARITY = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic clear_en,
    input  logic load_en,
    input  logic din,
    output logic q
);

    always_ff @(posedge clk) begin
        if (rst || clear_en) begin
            q <= POLARITY;
        end else if (load_en && din) begin
            q <= ~POLARITY;
        end
    end

    // R4
    cell_clear_chk: assert property (@(posedge clk) disable iff (rst)
        clear_en |=> (q == POLARITY));

    // R5
    cell_flip_chk: assert property (@(posedge clk) disable iff (rst)
        (load_en && din) |=> (q != POLARITY));

    // R6
    cell_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (!clear_en && !load_en) |=> $stable(q));

endmodule

// File: rtl/mdec_minority.sv
module mdec_minority #(
    parameter int WIDTH = 5
) (
    input  logic [WIDTH-1:0] vin,
    output logic             y
);

    localparam int CNT_W    = $clog2(WIDTH + 1);
    localparam int MAJ_THRS = (WIDTH + 1) / 2;

    logic [CNT_W-1:0] ones;

    always_comb begin
        ones = '0;
        for (int i = 0; i < WIDTH; i++) begin
            ones = ones + CNT_W'(vin[i]);
        end
        y = (ones < CNT_W'(MAJ_THRS));
    end

endmodule

// File: rtl/phased_minority_decoder.sv
module phased_minority_decoder #(
    parameter int N_ADDR = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     en_n,
    input  logic [N_ADDR-1:0]        addr,
    output logic [(1<<N_ADDR)-1:0]   dec_out,
    output logic [1:0]               phase_code,
    output logic                     result_valid
);

    localparam int N_OUT  = 1 << N_ADDR;
    localparam int N_OPS  = N_ADDR + 1;
    localparam int N_TIE  = N_OPS - 1;
    localparam int GATE_W = N_OPS + N_TIE;

    logic             clear_en;
    logic             load_en;
    logic             eval_en;
    logic             last_eval;
    logic [N_OUT-1:0] gate_y;

    mdec_sequencer u_seq (
        .clk        (clk),
        .rst        (rst),
        .clear_en   (clear_en),
        .load_en    (load_en),
        .eval_en    (eval_en),
        .last_eval  (last_eval),
        .phase_code (phase_code)
    );

    for (genvar g = 0; g < N_OUT; g++) begin : g_gate
        logic [N_OPS-1:0] ops;

        mdec_store_cell #(.POLARITY(1'b0)) u_en_cell (
            .clk      (clk),
            .rst      (rst),
            .clear_en (clear_en),
            .load_en  (load_en),
            .din      (en_n),
            .q        (ops[N_ADDR])
        );

        for (genvar j = 0; j < N_ADDR; j++) begin : g_addr
            localparam bit POL = (((g >> j) & 1) == 0) ? 1'b0 : 1'b1;
            mdec_store_cell #(.POLARITY(POL)) u_cell (
                .clk      (clk),
                .rst      (rst),
                .clear_en (clear_en),
                .load_en  (load_en),
                .din      (addr[j]),
                .q        (ops[j])
            );
        end

        mdec_minority #(.WIDTH(GATE_W)) u_min (
            .vin ({{N_TIE{1'b1}}, ops}),
            .y   (gate_y[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_out <= '0;
        end else if (eval_en) begin
            dec_out <= gate_y;
        end
    end

    assign result_valid = last_eval;

    // R2
    out_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(dec_out));

    // R7
    out_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        !eval_en |=> $stable(dec_out));

    // R8
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        result_valid |=> !result_valid);

    // R9
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (dec_out == '0 && phase_code == 2'd0 && !result_valid));

endmodule

// File: tb/test_phased_minority_decoder.sv
module test_phased_minority_decoder;

    localparam int CLK_PERIOD = 10;
    localparam int N_VEC      = 8;

    // {en_n, addr[1:0], expected dec_out[3:0]}
    localparam bit [6:0] VEC [N_VEC] = '{
        {1'b0, 2'd0, 4'b0001},
        {1'b0, 2'd1, 4'b0010},
        {1'b0, 2'd2, 4'b0100},
        {1'b0, 2'd3, 4'b1000},
        {1'b1, 2'd0, 4'b0000},
        {1'b1, 2'd1, 4'b0000},
        {1'b1, 2'd2, 4'b0000},
        {1'b1, 2'd3, 4'b0000}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en_n = 1'b1;
    logic [1:0] addr = 2'd0;
    logic [3:0] dec_out;
    logic [1:0] phase_code;
    logic       result_valid;

    int n_checks = 0;
    int n_fail   = 0;

    phased_minority_decoder i_phased_minority_decoder (
        .clk          (clk),
        .rst          (rst),
        .en_n         (en_n),
        .addr         (addr),
        .dec_out      (dec_out),
        .phase_code   (phase_code),
        .result_valid (result_valid)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // leaves the bench at the falling edge inside unit 0
    task automatic wait_clear();
        @(negedge clk);
        while (phase_code != 2'd0) @(negedge clk);
    endtask

    task automatic frame(input bit s, input bit [1:0] a, input bit [3:0] exp, input string req);
        wait_clear();
        en_n = s;
        addr = a;
        repeat (5) @(negedge clk);
        chk({req, " valid"}, int'(result_valid), 1);
        chk({req, " dec_out"}, int'(dec_out), int'(exp));
    endtask

    task automatic run_all();
        // R9: state held in reset
        repeat (3) @(negedge clk);
        chk("R9 reset dec_out", int'(dec_out), 0);
        chk("R9 reset phase", int'(phase_code), 0);
        chk("R9 reset valid", int'(result_valid), 0);
        rst = 1'b0;

        // R1 R2: walk the vector table
        for (int i = 0; i < N_VEC; i++) begin
            frame(VEC[i][6], VEC[i][5:4], VEC[i][3:0], "R1 R2 table");
        end

        // R3 R8: phase code and valid pulse across one cycle
        wait_clear();
        for (int u = 0; u < 6; u++) begin
            chk("R3 phase", int'(phase_code), (u == 0) ? 0 : ((u < 3) ? 1 : 2));
            chk("R8 valid", int'(result_valid), (u == 5) ? 1 : 0);
            if (u < 5) @(negedge clk);
        end

        // R4: a cycle loading 11 then a cycle loading 00
        frame(1'b0, 2'd3, 4'b1000, "R4 pre");
        frame(1'b0, 2'd0, 4'b0001, "R4 cleared");

        // R7: old result held through units 0..3, new one by unit 4
        wait_clear();
        en_n = 1'b0;
        addr = 2'd2;
        for (int u = 0; u < 4; u++) begin
            chk("R7 held", int'(dec_out), 1);
            @(negedge clk);
        end
        chk("R7 updated", int'(dec_out), 4);

        // R5: 1 seen at unit 1, then 0 at unit 2, still counts as 1
        wait_clear();
        en_n = 1'b0;
        addr = 2'd3;
        repeat (2) @(negedge clk);
        addr = 2'd0;
        repeat (3) @(negedge clk);
        chk("R5 sticky load", int'(dec_out), 8);

        // R6: changes made during the hold units are ignored
        wait_clear();
        en_n = 1'b0;
        addr = 2'd1;
        repeat (3) @(negedge clk);
        addr = 2'd2;
        en_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R6 late change ignored", int'(dec_out), 2);
        // the late value is picked up on the next cycle's load
        frame(1'b1, 2'd2, 4'b0000, "R6 next cycle");
        frame(1'b0, 2'd1, 4'b0010, "R6 restore");

        // R9: reset in mid-cycle
        wait_clear();
        repeat (4) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R9 mid dec_out", int'(dec_out), 0);
        chk("R9 mid phase", int'(phase_code), 0);
        chk("R9 mid valid", int'(result_valid), 0);
        rst = 1'b0;
        frame(1'b0, 2'd2, 4'b0100, "R9 after reset");
    endtask

    initial begin
        fork
            run_all();
            begin
                #(CLK_PERIOD * 20000);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule